// File: doc/BRIEF.md
# Eight-Channel TDM Serial Port

This block links up to eight processors over a small set of shared serial lines: one serial clock, one frame sync, one data line and one address line. A frame is 128 serial clocks long and is split into eight slots of sixteen bit times each. Every node owns exactly one slot, in which it sends a 16-bit word MSB first on the data line. In the first eight bit times of that slot it also sends an eight-bit destination mask on the address line. Outside its own slot a node releases both lines.

Every node listens to every slot. It keeps a slot's word when two things are true: the slot's channel is enabled in the node's receive mask, and the bit of the node's own channel number is set in the destination mask sent in that slot. Both directions are double-buffered. A written transmit word waits in a holding register until the node's slot begins, and the word already being shifted is not disturbed. A received word is moved into a receive buffer, and it stays there until the next capture overwrites it. The serial clock comes from a fixed divider of the system clock, and all logic runs on the system clock.

Top module: `tdm_port`

## Requirements
- R1: The serial clock is high for HALF_DIV system clocks and then low for HALF_DIV system clocks (a period of 4 with the default of 2). The frame sync output is high for exactly one serial period, in bit time 0 of each frame. The first rising serial edge after reset starts frame 0, and the frame sync then repeats every 128 rising serial edges.
- R2: The line output enable is high only during the node's own slot (slot number equal to the channel select), and only when a word was loaded at the start of that slot. Otherwise it is low, and the data and address outputs are 0.
- R3: In the node's own slot, bit time k (k = 0..15) carries bit 15-k of the loaded word on the data output. The outputs change only on the system clock edge that makes the serial clock rise.
- R4: In the node's own slot, the address output carries destination mask bit k in bit time k for k = 0..7, and 0 in bit times 8..15.
- R5: A transmit write loads the holding register and sets the transmit-full flag. When the own slot starts with the flag set, the held word moves to the shifter, the transmit-ready output pulses for one system clock, and the flag clears. A write while a word is shifting does not disturb that word. A second write before the slot overwrites the first.
- R6: Inputs are sampled on falling serial edges. At the end of slot s, the word is captured when receive-enable bit s is set and the mask bit equal to the channel select was 1 in the slot's address field. On capture the receive data updates, the receive channel output reads s, the receive-full flag sets, and receive-ready pulses for one system clock.
- R7: A slot whose receive-enable bit is clear, or whose destination mask lacks the node's bit, is ignored: no receive-ready pulse and no change to the receive data.
- R8: A capture while the receive-full flag is set and no read is presented replaces the buffer and sets the overrun flag. With every word read in time, the overrun flag stays low.
- R9: A receive read strobe clears the receive-full and overrun flags.
- R10: After reset the serial clock, frame sync, line enable, transmit-full, receive-full and overrun outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| my_ch | input | 3 | Own channel: the transmit slot, and the bit looked up in incoming masks |
| rx_en | input | 8 | Receive-enable mask, one bit per slot |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 16 | Word to transmit |
| tx_wmask | input | 8 | Destination mask to send with the word |
| tx_full | output | 1 | Holding register occupied |
| tx_int | output | 1 | One-cycle pulse when the held word moves to the shifter |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 16 | Last captured word |
| rx_chan | output | 3 | Slot the last word came from |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_overrun | output | 1 | An unread word was overwritten |
| rx_int | output | 1 | One-cycle pulse on capture |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync, high in bit time 0 |
| data_out | output | 1 | Data line drive value |
| addr_out | output | 1 | Address line drive value |
| line_oe | output | 1 | Drive enable for data and address lines |
| data_in | input | 1 | Resolved shared data line |
| addr_in | input | 1 | Resolved shared address line |

## Verification
Several properties are checked on every cycle. Frame syncs must be spaced exactly one frame of rising serial edges apart. The line may be driven only in the selected slot, and the data output may move only on a rising-edge tick. A load pulse must leave the holding register empty unless a write arrived in the same cycle. Capture must set the full flag, and capture onto a full, unread buffer must raise overrun. Other behaviour only the bench scenarios can show. These are the bit-by-bit content of the data and mask on the line, the decision to capture or skip across all eight channel selects and several enable patterns, loopback of the node's own word, the double-buffered and overwritten transmit sequences, and the clearing of flags by a read.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // position arithmetic shared by the datapath; the bench restates it on its own
  function automatic int slot_of(int pos, int word_w);
    return pos / word_w;
  endfunction

  function automatic int bit_of(int pos, int word_w);
    return pos % word_w;
  endfunction

  function automatic int next_pos(int pos, int frame_len);
    return (pos + 1) % frame_len;
  endfunction
endpackage

// File: rtl/tdm_clkdiv.sv
module tdm_clkdiv #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = (cnt == CW'(HALF_DIV - 1));
  assign rise_evt = tick && !sclk;
  assign fall_evt = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int WORD_W = 16,
  parameter int NCH    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_evt,
  input  logic              slot_boundary,
  input  logic              own_start,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NCH-1:0]    wmask,
  output logic              full,
  output logic              load_pulse,
  output logic              data_o,
  output logic              addr_o,
  output logic              oe_o
);
  logic [WORD_W-1:0] hold_w, sh_w;
  logic [NCH-1:0]    hold_m, sh_m;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_w     <= '0;
      hold_m     <= '0;
      sh_w       <= '0;
      sh_m       <= '0;
      full       <= 1'b0;
      active     <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= 1'b0;
      if (wr) begin
        hold_w <= wdata;
        hold_m <= wmask;
        full   <= 1'b1;
      end
      if (rise_evt) begin
        if (slot_boundary) begin
          if (own_start && full) begin
            sh_w       <= hold_w;
            sh_m       <= hold_m;
            active     <= 1'b1;
            load_pulse <= 1'b1;
            if (!wr) full <= 1'b0;
          end else begin
            active <= 1'b0;
          end
        end else if (active) begin
          sh_w <= {sh_w[WORD_W-2:0], 1'b0};
          sh_m <= {1'b0, sh_m[NCH-1:1]};
        end
      end
    end
  end

  assign data_o = active & sh_w[WORD_W-1];
  assign addr_o = active & sh_m[0];
  assign oe_o   = active;
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int WORD_W = 16,
  parameter int NCH    = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_evt,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic [CH_W-1:0]   cur_slot,
  input  logic [CH_W-1:0]   my_ch,
  input  logic [NCH-1:0]    rx_en,
  input  logic              data_i,
  input  logic              addr_i,
  input  logic              rd,
  output logic [WORD_W-1:0] rbuf,
  output logic [CH_W-1:0]   rchan,
  output logic              full,
  output logic              overrun,
  output logic              cap_pulse
);
  logic [WORD_W-1:0] sh;
  logic [NCH-1:0]    amask;
  logic              last_bit, hit;

  assign last_bit = (cur_bit == BIT_W'(WORD_W - 1));
  assign hit      = rx_en[cur_slot] && amask[my_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      amask     <= '0;
      rbuf      <= '0;
      rchan     <= '0;
      full      <= 1'b0;
      overrun   <= 1'b0;
      cap_pulse <= 1'b0;
    end else begin
      cap_pulse <= 1'b0;
      if (rd) begin
        full    <= 1'b0;
        overrun <= 1'b0;
      end
      if (fall_evt) begin
        sh <= {sh[WORD_W-2:0], data_i};
        if (cur_bit < BIT_W'(NCH)) amask[cur_bit[CH_W-1:0]] <= addr_i;
        if (last_bit && hit) begin
          rbuf      <= {sh[WORD_W-2:0], data_i};
          rchan     <= cur_slot;
          full      <= 1'b1;
          cap_pulse <= 1'b1;
          if (full && !rd) overrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NCH      = 8,
  parameter int HALF_DIV = 2,
  localparam int CH_W    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   my_ch,
  input  logic [NCH-1:0]    rx_en,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic [NCH-1:0]    tx_wmask,
  output logic              tx_full,
  output logic              tx_int,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_data,
  output logic [CH_W-1:0]   rx_chan,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rx_int,
  output logic              sclk,
  output logic              fsync,
  output logic              data_out,
  output logic              addr_out,
  output logic              line_oe,
  input  logic              data_in,
  input  logic              addr_in
);
  localparam int FRAME = NCH * WORD_W;
  localparam int POS_W = $clog2(FRAME);
  localparam int BIT_W = $clog2(WORD_W);

  // named internal events, also used by the bound checker
  logic             rise_evt, fall_evt;
  logic [POS_W-1:0] bitpos, nxt_pos;
  logic [CH_W-1:0]  cur_slot, nxt_slot;
  logic [BIT_W-1:0] cur_bit, nxt_bit;
  logic             slot_boundary, own_start;

  tdm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  assign nxt_pos  = POS_W'(next_pos(int'(bitpos), FRAME));
  assign cur_slot = CH_W'(slot_of(int'(bitpos), WORD_W));
  assign cur_bit  = BIT_W'(bit_of(int'(bitpos), WORD_W));
  assign nxt_slot = CH_W'(slot_of(int'(nxt_pos), WORD_W));
  assign nxt_bit  = BIT_W'(bit_of(int'(nxt_pos), WORD_W));

  assign slot_boundary = rise_evt && (nxt_bit == '0);
  assign own_start     = slot_boundary && (nxt_slot == my_ch);

  // position starts at the last bit so the first rising edge opens frame 0
  always_ff @(posedge clk) begin
    if (rst)           bitpos <= '1;
    else if (rise_evt) bitpos <= nxt_pos;
  end

  assign fsync = (bitpos == '0);

  tdm_tx #(.WORD_W(WORD_W), .NCH(NCH)) u_tx (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .slot_boundary(slot_boundary),
    .own_start(own_start), .wr(tx_wr), .wdata(tx_wdata), .wmask(tx_wmask),
    .full(tx_full), .load_pulse(tx_int), .data_o(data_out), .addr_o(addr_out),
    .oe_o(line_oe)
  );

  tdm_rx #(.WORD_W(WORD_W), .NCH(NCH)) u_rx (
    .clk(clk), .rst(rst), .fall_evt(fall_evt), .cur_bit(cur_bit),
    .cur_slot(cur_slot), .my_ch(my_ch), .rx_en(rx_en), .data_i(data_in),
    .addr_i(addr_in), .rd(rx_rd), .rbuf(rx_data), .rchan(rx_chan),
    .full(rx_full), .overrun(rx_overrun), .cap_pulse(rx_int)
  );
endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk #(
  parameter int FRAME = 128,
  parameter int CH_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rise_evt,
  input logic            fsync,
  input logic            line_oe,
  input logic            data_out,
  input logic [CH_W-1:0] cur_slot,
  input logic [CH_W-1:0] my_ch,
  input logic            tx_wr,
  input logic            tx_int,
  input logic            tx_full,
  input logic            rx_int,
  input logic            rx_full,
  input logic            rx_rd,
  input logic            rx_overrun
);
  int unsigned rises, mark;
  logic        seen_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      rises     <= 0;
      mark      <= 0;
      seen_sync <= 1'b0;
    end else begin
      if (rise_evt) rises <= rises + 1;
      if (fsync && !$past(fsync)) begin
        mark      <= rises;
        seen_sync <= 1'b1;
      end
    end
  end

  // R1
  sync_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(fsync) && seen_sync) |-> (rises - mark == FRAME));

  // R2
  oe_own_slot_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> (cur_slot == my_ch));

  // R3
  data_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> $past(rise_evt));

  // R5
  tx_drain_chk: assert property (@(posedge clk) disable iff (rst)
    tx_int |-> (!tx_full || $past(tx_wr)));

  // R6
  rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
    rx_int |-> rx_full);

  // R8
  rx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_int && $past(rx_full) && !$past(rx_rd)) |-> rx_overrun);
endmodule

bind tdm_port tdm_port_chk #(.FRAME(NCH * WORD_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .rise_evt(rise_evt), .fsync(fsync), .line_oe(line_oe),
  .data_out(data_out), .cur_slot(cur_slot), .my_ch(my_ch), .tx_wr(tx_wr),
  .tx_int(tx_int), .tx_full(tx_full), .rx_int(rx_int), .rx_full(rx_full),
  .rx_rd(rx_rd), .rx_overrun(rx_overrun)
);

// File: tb/tb_tdm_port.sv
module tb_tdm_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  my_ch = 3'd0;
  logic [7:0]  rx_en = 8'h00;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic [7:0]  tx_wmask = '0;
  logic        tx_full, tx_int, rx_rd = 1'b0;
  logic [15:0] rx_data;
  logic [2:0]  rx_chan;
  logic        rx_full, rx_overrun, rx_int;
  logic        sclk, fsync, data_out, addr_out, line_oe;
  logic        b_data = 1'b0, b_addr = 1'b0;
  logic        data_in, addr_in;

  assign data_in = line_oe ? data_out : b_data;
  assign addr_in = line_oe ? addr_out : b_addr;

  tdm_port dut (
    .clk(clk), .rst(rst), .my_ch(my_ch), .rx_en(rx_en), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_wmask(tx_wmask), .tx_full(tx_full), .tx_int(tx_int),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_chan(rx_chan), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_int(rx_int), .sclk(sclk), .fsync(fsync),
    .data_out(data_out), .addr_out(addr_out), .line_oe(line_oe),
    .data_in(data_in), .addr_in(addr_in)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, last_cyc = 0, nrise = 0;
  int pos = -1, fr = 0, slot = 0, idx = 0;
  bit quiet = 1, q_snap = 1, auto_rd = 1, force_all = 0, seen = 0, have_exp = 0;
  bit exp_hit = 0;
  logic [15:0] exp_word = '0;
  bit tbuf_v = 0, cur_v = 0;
  logic [15:0] tbuf_w = '0, cur_w = '0;
  logic [7:0]  tbuf_m = '0, cur_m = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] word_of(int f, int s);
    return 16'((f * 4111 + s * 997) ^ 16'hC35A);
  endfunction

  function automatic logic [7:0] mask_of(int f, int s);
    if (force_all) return 8'hFF;
    return 8'((f * 29 + s * 53 + 7) ^ 8'h3C);
  endfunction

  always @(posedge clk) cyc++;

  // serial-side model: tracks position from its own count of rising edges
  always @(posedge sclk) begin
    #1;
    if (nrise > 0) chk(cyc - last_cyc == 4, "R1 sclk period", cyc - last_cyc, 4);
    last_cyc = cyc;
    pos = nrise % 128;
    fr  = nrise / 128;
    nrise++;
    slot = pos / 16;
    idx  = pos % 16;
    chk(fsync == (pos == 0), "R1 fsync", fsync, pos == 0);
    if (idx == 0) begin
      if (have_exp && !q_snap) chk(seen == exp_hit, "R6/R7 capture decision", seen, exp_hit);
      seen = 0;
      if (slot == my_ch) begin
        chk(tx_int == tbuf_v, "R5 load pulse", tx_int, tbuf_v);
        cur_v = tbuf_v; cur_w = tbuf_w; cur_m = tbuf_m; tbuf_v = 0;
        chk(tx_full == 0, "R5 full cleared", tx_full, 0);
      end else begin
        cur_v = 0;
      end
    end
    if (idx == 15) begin
      q_snap = quiet;
      have_exp = 1;
      if (slot == my_ch) begin
        exp_hit  = cur_v && rx_en[slot] && cur_m[my_ch];
        exp_word = cur_w;
      end else begin
        exp_hit  = rx_en[slot] && mask_of(fr, slot)[my_ch];
        exp_word = word_of(fr, slot);
      end
    end
    if (slot != my_ch) begin
      b_data = word_of(fr, slot)[15 - idx];
      b_addr = (idx < 8) ? mask_of(fr, slot)[idx] : 1'b0;
    end else begin
      b_data = 1'b0; b_addr = 1'b0;
    end
    chk(line_oe == cur_v, "R2 line enable", line_oe, cur_v);
    if (cur_v) begin
      chk(data_out == cur_w[15 - idx], "R3 data bit", data_out, cur_w[15 - idx]);
      chk(addr_out == ((idx < 8) ? cur_m[idx] : 1'b0), "R4 mask bit", addr_out,
          (idx < 8) ? cur_m[idx] : 1'b0);
    end else begin
      chk(data_out == 0 && addr_out == 0, "R2 released lines", {data_out, addr_out}, 0);
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (auto_rd) rx_rd = rx_int;
    if (rx_int) begin
      seen = 1;
      if (!q_snap) begin
        chk(exp_hit, "R7 unexpected capture", 1, exp_hit);
        chk(rx_data == exp_word, "R6 rx data", rx_data, exp_word);
        chk(rx_chan == 3'(slot), "R6 rx channel", rx_chan, slot);
        chk(rx_full, "R6 rx full", rx_full, 1);
        if (auto_rd) chk(!rx_overrun, "R8 no overrun when read", rx_overrun, 0);
      end
    end
  end

  task automatic wait_pos(int target);
    do begin
      @(posedge sclk); #2;
    end while (pos != target);
  endtask

  task automatic set_cfg(int ch, logic [7:0] en);
    quiet = 1;
    my_ch = 3'(ch);
    rx_en = en;
    wait_pos(0);
    quiet = 0;
  endtask

  task automatic tx_write(logic [15:0] w, logic [7:0] m);
    @(negedge clk);
    tx_wr = 1; tx_wdata = w; tx_wmask = m;
    @(negedge clk);
    tx_wr = 0;
    tbuf_v = 1; tbuf_w = w; tbuf_m = m;
    chk(tx_full, "R5 full after write", tx_full, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(!sclk && !fsync && !line_oe, "R10 reset lines", {sclk, fsync, line_oe}, 0);
    chk(!tx_full && !rx_full && !rx_overrun, "R10 reset flags",
        {tx_full, rx_full, rx_overrun}, 0);
    rst = 0;

    // sweep of every channel select with two enable patterns (R6, R7)
    for (int ch = 0; ch < 8; ch++) begin
      set_cfg(ch, 8'hFF);
      wait_pos(0);
      set_cfg(ch, 8'((8'hA5 << ch) | (8'hA5 >> (8 - ch))));
      wait_pos(0);
    end

    // transmit path with loopback into slot 3 (R2..R5)
    set_cfg(3, 8'b0000_1001);
    wait_pos(7 * 16);
    tx_write(16'hB38D, 8'h08);
    wait_pos(3 * 16 + 4);
    tx_write(16'h6A1F, 8'hF0);      // arrives while first word shifts
    wait_pos(3 * 16 + 8);
    wait_pos(3 * 16 + 8);
    chk(!tx_full, "R5 second word loaded", tx_full, 0);
    wait_pos(7 * 16);
    tx_write(16'h1111, 8'h01);
    tx_write(16'hE0C7, 8'h0F);      // overwrites the held word
    wait_pos(5 * 16);
    wait_pos(5 * 16);               // frame with nothing held: line stays released

    // overrun and read clearing (R8, R9)
    auto_rd = 0;
    force_all = 1;
    set_cfg(2, 8'hFB);
    wait_pos(5);
    chk(rx_overrun, "R8 overrun set", rx_overrun, 1);
    chk(rx_full, "R8 full kept", rx_full, 1);
    chk(rx_data == word_of(fr - 1, 7), "R8 last word kept", rx_data, word_of(fr - 1, 7));
    chk(rx_chan == 3'd7, "R8 last channel", rx_chan, 7);
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
    chk(!rx_full, "R9 full cleared", rx_full, 0);
    chk(!rx_overrun, "R9 overrun cleared", rx_overrun, 0);
    finish_run();
  end
endmodule